// File: doc/BRIEF.md
# Phase-Accumulator NCO with FSK/PSK Control

This block is a numerically controlled oscillator for direct digital synthesis. On every clock it adds a 48-bit frequency word to a 48-bit phase accumulator. The frequency word is the sum of a center word and an offset word. A single enable input forces the offset term to zero, so toggling that input switches between two tones for binary FSK.

A two-bit quadrant input rotates the accumulated phase by a multiple of 90 degrees, which gives four-level PSK. The top 12 bits of the rotated phase address a quarter-wave sine table. The table is built at elaboration, and its result leaves the block as a 14-bit offset-binary sample for a DAC.

The center and offset words come from registers that are latched outside this block. The pipeline depth is fixed, so every control change reaches the sample a known number of edges later.

Top module: `nco_synth`

## Requirements
- R1: With `offsetEn` high, the word added to the accumulator is `centerWord + offsetWord` modulo 2^48.
- R2: With `offsetEn` low, the value on `offsetWord` has no effect on the sample stream; only `centerWord` is accumulated.
- R3: The accumulator adds the frequency word once per clock and wraps modulo 2^48.
- R4: `phaseSel` value k (0 to 3) adds k times 90 degrees, meaning k is added modulo 4 to bits [47:46] of the accumulated phase before the lookup.
- R5: The sample equals 8192 + round(8191 * sin(2*pi*p/4096)), where p is bits [47:36] of the rotated phase (offset binary).
- R6: Inputs sampled at rising edge t first show at `sample` right after rising edge t+13, which is the 14th rising edge counting edge t.
- R7: `offsetEn` may change every second clock, and every such change is carried through to the sample without loss.
- R8: A synchronous active-high `rst` clears the accumulator and all pipeline stages. `sample` reads 8192 after the reset edge and stays at 8192 for the next 13 edges.
- R9: `sample` never reads 0; its range is 1 to 16383.
- R10: At the quadrant boundaries p = 0, 1024, 2048 and 3072, the sample reads 8192, 16383, 8192 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| centerWord | input | 48 | Center frequency word |
| offsetWord | input | 48 | Offset frequency word |
| offsetEn | input | 1 | Adds the offset word when high, zeroes it when low |
| phaseSel | input | 2 | Quadrant phase rotation, 0/90/180/270 degrees |
| sample | output | 14 | Offset-binary sine sample |

## Verification
Frequency keying and phase keying can land on the same clock edge. A change of `offsetEn` then alters the slope of the accumulator, while a change of `phaseSel` rotates the phase directly. Both must surface together exactly 13 edges later. The bench provokes this by toggling `offsetEn` every second clock while it randomizes `phaseSel` on every clock. It judges each cycle against a behavioural model that applies both effects to the same sampled edge and delays the result through a queue.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef struct packed {
    logic       addOffset;  // offset term enabled for the word being formed
    logic [1:0] quadSel;    // quadrant, aligned with the accumulator output
  } ctrlStrobes_t;
endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         offsetEn,
  input  logic [1:0]   phaseSel,
  output ctrlStrobes_t strobes
);
  // quadrant travels three stages to meet the accumulator result
  localparam int QUAD_DELAY = 3;

  logic       enQ;
  logic [1:0] selPipe [QUAD_DELAY];

  always_ff @(posedge clk) begin
    if (rst) begin
      enQ <= 1'b0;
      for (int k = 0; k < QUAD_DELAY; k++) selPipe[k] <= '0;
    end else begin
      enQ        <= offsetEn;
      selPipe[0] <= phaseSel;
      for (int k = 1; k < QUAD_DELAY; k++) selPipe[k] <= selPipe[k-1];
    end
  end

  assign strobes.addOffset = enQ;
  assign strobes.quadSel   = selPipe[QUAD_DELAY-1];
endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
#(
  parameter int FREQ_W     = 48,
  parameter int PHASE_BITS = 12,
  parameter int SAMPLE_W   = 14,
  parameter int PIPE_DEPTH = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FREQ_W-1:0]   centerWord,
  input  logic [FREQ_W-1:0]   offsetWord,
  input  ctrlStrobes_t        strobes,
  output logic [SAMPLE_W-1:0] sample
);
  localparam int ADDR_W      = PHASE_BITS - 2;
  localparam int QUARTER     = 1 << ADDR_W;
  localparam int MAG_W       = SAMPLE_W - 1;
  localparam int AMP         = (1 << MAG_W) - 1;
  localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1 << MAG_W);
  localparam int CORE_STAGES = 7;
  localparam int PAD         = PIPE_DEPTH - CORE_STAGES;

  function automatic int quarterSine(input int idx);
    real ang;
    ang = 2.0 * 3.14159265358979 * real'(idx) / (4.0 * real'(QUARTER));
    return int'(real'(AMP) * $sin(ang));
  endfunction

  logic [MAG_W-1:0] sineRom [QUARTER];
  for (genvar i = 0; i < QUARTER; i++) begin : g_rom
    assign sineRom[i] = MAG_W'(quarterSine(i));
  end

  logic [FREQ_W-1:0]     centerQ, offsetQ, freqWord, acc;
  logic [PHASE_BITS-1:0] phase;
  logic [ADDR_W:0]       mirrorAddr;
  logic [ADDR_W-1:0]     romAddr;
  logic                  peakSel, negA, negB;
  logic [MAG_W-1:0]      mag;
  logic [SAMPLE_W-1:0]   coreOut;

  assign mirrorAddr = (ADDR_W+1)'(QUARTER) - {1'b0, phase[ADDR_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      centerQ  <= '0;
      offsetQ  <= '0;
      freqWord <= '0;
      acc      <= '0;
      phase    <= '0;
      romAddr  <= '0;
      peakSel  <= 1'b0;
      negA     <= 1'b0;
      negB     <= 1'b0;
      mag      <= '0;
      coreOut  <= MID;
    end else begin
      centerQ  <= centerWord;
      offsetQ  <= offsetWord;
      freqWord <= centerQ + (strobes.addOffset ? offsetQ : '0);
      acc      <= acc + freqWord;
      phase    <= acc[FREQ_W-1 -: PHASE_BITS] + {strobes.quadSel, {(PHASE_BITS-2){1'b0}}};
      negA     <= phase[PHASE_BITS-1];
      if (phase[PHASE_BITS-2]) begin
        romAddr <= mirrorAddr[ADDR_W-1:0];
        peakSel <= (phase[ADDR_W-1:0] == '0);
      end else begin
        romAddr <= phase[ADDR_W-1:0];
        peakSel <= 1'b0;
      end
      mag      <= peakSel ? MAG_W'(AMP) : sineRom[romAddr];
      negB     <= negA;
      coreOut  <= negB ? (MID - {1'b0, mag}) : (MID + {1'b0, mag});
    end
  end

  if (PAD > 0) begin : g_pad
    logic [SAMPLE_W-1:0] padQ [PAD];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int k = 0; k < PAD; k++) padQ[k] <= MID;
      end else begin
        padQ[0] <= coreOut;
        for (int k = 1; k < PAD; k++) padQ[k] <= padQ[k-1];
      end
    end
    assign sample = padQ[PAD-1];
  end else begin : g_nopad
    assign sample = coreOut;
  end
endmodule

// File: rtl/nco_synth.sv
module nco_synth
  import nco_pkg::*;
#(
  parameter int FREQ_W     = 48,
  parameter int PHASE_BITS = 12,
  parameter int SAMPLE_W   = 14,
  parameter int PIPE_DEPTH = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FREQ_W-1:0]   centerWord,
  input  logic [FREQ_W-1:0]   offsetWord,
  input  logic                offsetEn,
  input  logic [1:0]          phaseSel,
  output logic [SAMPLE_W-1:0] sample
);
  ctrlStrobes_t strobes;

  nco_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .offsetEn (offsetEn),
    .phaseSel (phaseSel),
    .strobes  (strobes)
  );

  nco_datapath #(
    .FREQ_W     (FREQ_W),
    .PHASE_BITS (PHASE_BITS),
    .SAMPLE_W   (SAMPLE_W),
    .PIPE_DEPTH (PIPE_DEPTH)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .centerWord (centerWord),
    .offsetWord (offsetWord),
    .strobes    (strobes),
    .sample     (sample)
  );
endmodule

// File: rtl/nco_synth_chk.sv
module nco_synth_chk
  import nco_pkg::*;
#(
  parameter int SAMPLE_W   = 14,
  parameter int PIPE_DEPTH = 14
) (
  input logic                clk,
  input logic                rst,
  input logic                offsetEn,
  input logic [1:0]          phaseSel,
  input logic [SAMPLE_W-1:0] sample,
  input ctrlStrobes_t        strobes
);
  localparam int CNT_W = $clog2(PIPE_DEPTH + 1);
  localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1 << (SAMPLE_W - 1));

  logic [CNT_W-1:0] fillCnt;
  always_ff @(posedge clk) begin
    if (rst) fillCnt <= '0;
    else if (fillCnt < CNT_W'(PIPE_DEPTH)) fillCnt <= fillCnt + 1'b1;
  end

  AST_RESET_MIDSCALE: assert property (@(posedge clk)
    rst |=> sample == MID);  // R8
  AST_FILL_MIDSCALE: assert property (@(posedge clk) disable iff (rst)
    (fillCnt < CNT_W'(PIPE_DEPTH)) |-> sample == MID);  // R8
  AST_NO_ZERO_CODE: assert property (@(posedge clk) disable iff (rst)
    sample != '0);  // R9
  AST_OFFSET_STROBE: assert property (@(posedge clk) disable iff (rst)
    (fillCnt >= CNT_W'(1)) |-> strobes.addOffset == $past(offsetEn));  // R7
  AST_QUAD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (fillCnt >= CNT_W'(3)) |-> strobes.quadSel == $past(phaseSel, 3));  // R4
endmodule

bind nco_synth nco_synth_chk #(
  .SAMPLE_W   (SAMPLE_W),
  .PIPE_DEPTH (PIPE_DEPTH)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .offsetEn (offsetEn),
  .phaseSel (phaseSel),
  .sample   (sample),
  .strobes  (strobes)
);

// File: tb/nco_synth_bench.sv
`timescale 1ns/1ps
module nco_synth_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [47:0] centerWord = '0;
  logic [47:0] offsetWord = '0;
  logic        offsetEn = 1'b0;
  logic [1:0]  phaseSel = '0;
  logic [13:0] sample;

  always #2.5 clk = ~clk;

  nco_synth u_nco_synth (
    .clk(clk), .rst(rst), .centerWord(centerWord), .offsetWord(offsetWord),
    .offsetEn(offsetEn), .phaseSel(phaseSel), .sample(sample)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  string curReq  = "R8";
  bit    modelOn = 1'b0;
  bit    finished = 1'b0;
  int    expSample = 8192;
  int    expQ[$];
  logic [47:0] mAcc = '0;

  function automatic int refSine(input logic [11:0] p);
    real v;
    v = 8191.0 * $sin(2.0 * 3.14159265358979 * real'(p) / 4096.0);
    return 8192 + int'(v);
  endfunction

  function automatic logic [47:0] rand48();
    return {$urandom, $urandom} >> 16;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: accumulate in 48 bits, rotate, look up, delay 13 edges
  always @(posedge clk) begin
    if (rst) begin
      mAcc = '0;
      expQ.delete();
      for (int k = 0; k < 13; k++) expQ.push_back(8192);
      expSample = 8192;
      modelOn = 1'b1;
    end else begin
      logic [11:0] p;
      mAcc = mAcc + centerWord + (offsetEn ? offsetWord : 48'd0);
      p = mAcc[47:36] + {phaseSel, 10'd0};
      expQ.push_back(refSine(p));
      expSample = expQ.pop_front();
    end
  end

  always @(negedge clk) begin
    if (modelOn && !finished) begin
      check(curReq, int'(sample), expSample);
      check("R9", int'(sample != 14'd0), 1);
    end
  end

  initial begin
    int quadExp[4] = '{8192, 16383, 8192, 1};
    repeat (3) @(negedge clk);
    check("R8", int'(sample), 8192);
    rst = 1'b0;
    // R10 / R4: zero frequency, quadrant steps only
    curReq = "R4 R10";
    for (int k = 0; k < 4; k++) begin
      phaseSel = 2'(k);
      repeat (16) @(negedge clk);
      check("R10", int'(sample), quadExp[k]);
    end
    // R6: quadrant change reaches the sample on the 14th edge
    curReq = "R6";
    phaseSel = 2'd1;
    repeat (13) @(posedge clk);
    @(negedge clk);
    check("R6", int'(sample), 1);
    @(posedge clk);
    @(negedge clk);
    check("R6", int'(sample), 16383);
    // R1 R3 R5: random words with offset enabled, wraps often
    curReq = "R1 R3 R5";
    offsetEn = 1'b1;
    for (int i = 0; i < 150; i++) begin
      centerWord = rand48();
      offsetWord = rand48();
      phaseSel   = 2'($urandom);
      @(negedge clk);
    end
    // R2: offset disabled, offset word churns
    curReq = "R2";
    offsetEn = 1'b0;
    centerWord = 48'h0123_4567_89AB;
    phaseSel = 2'd0;
    for (int i = 0; i < 100; i++) begin
      offsetWord = rand48();
      @(negedge clk);
    end
    // R7: offset enable toggles every second clock, with quadrant changes
    curReq = "R7";
    centerWord = 48'h0000_1000_0000;
    offsetWord = 48'h2000_0000_0000;
    for (int i = 0; i < 200; i++) begin
      offsetEn = i[1];
      phaseSel = 2'($urandom);
      @(negedge clk);
    end
    // R8: reset in mid-run
    curReq = "R8";
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R8", int'(sample), 8192);
    rst = 1'b0;
    curReq = "R3";
    for (int i = 0; i < 60; i++) begin
      centerWord = rand48();
      offsetEn   = 1'($urandom);
      @(negedge clk);
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule